// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address to a physical address after a translation lookaside buffer has missed. A requester hands it a 31-bit virtual address and says whether the access is a load or a store. The walker then reads page table entries one at a time through a plain request/response memory port. It reports either a 27-bit physical address or a page fault. When a translation succeeds, the walker also writes the leaf entry back with its access-tracking bits updated. A root-table base address is supplied on a separate input and is held stable by its owner.

Pages are 4 KiB, so the low 12 bits of the address bypass translation. The 19-bit page number is split in two. The upper 9 bits index a 512-entry root table, and the lower 10 bits index a 1024-entry leaf table. Every entry is one 32-bit word laid out as follows:

| Bit(s) | Meaning |
|---|---|
| 31 | valid |
| 30 | referenced |
| 29 | modified |
| low bits | table base (root entry) or physical page number (leaf entry) |

The control is a single state machine with eight states:

| State | What it does | Transitions |
|---|---|---|
| `S_IDLE` | Waits for a request. | Goes to `S_RD_ROOT` when a request is accepted. |
| `S_RD_ROOT` | Issues the root-entry read. | Always goes to `S_WT_ROOT`. |
| `S_WT_ROOT` | Waits for the root-entry response. | Goes to `S_RD_LEAF` if the root entry is valid. Goes to `S_REPORT` with a fault if it is not. |
| `S_RD_LEAF` | Issues the leaf-entry read. | Always goes to `S_WT_LEAF`. |
| `S_WT_LEAF` | Waits for the leaf-entry response. | Goes to `S_WR_LEAF` if the leaf entry is valid and its tracking bits must change. Goes to `S_REPORT` if the leaf entry is valid and the bits are already set. Goes to `S_REPORT` with a fault if the leaf entry is invalid. |
| `S_WR_LEAF` | Issues the leaf-entry write. | Always goes to `S_WT_WR`. |
| `S_WT_WR` | Waits for the write acknowledge. | Goes to `S_REPORT` on the acknowledge. |
| `S_REPORT` | Presents the result for one cycle. | Always goes back to `S_IDLE`. |

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy` and `done_valid` are 0, `mem_req_valid` is 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` is high while `req_ready` is high. `busy` is high from the next cycle up to and including the cycle in which `done_valid` is high, and low in the cycle after. A `req_valid` raised while busy is ignored: it causes no extra memory access and no extra result.
- R3: The first read goes to byte address `root_base + va[30:22]*4`.
- R4: A root entry with bit 31 clear ends the walk with `done_fault`=1 after that single read.
- R5: For a valid root entry, the second read goes to `entry[26:0] + va[21:12]*4`.
- R6: A leaf entry with bit 31 clear ends the walk with `done_fault`=1, and no write is made.
- R7: A valid leaf entry yields `done_paddr = {leaf[14:0], va[11:0]}` with `done_fault`=0.
- R8: On success, the leaf word written back equals the old word with bit 30 set, and with bit 29 also set when the access is a store. The write goes to the leaf's address and is issued only if the word changes. Otherwise the walk makes exactly two reads and no write.
- R9: Each memory request is high for exactly one cycle, and no new request is issued before `mem_rsp_valid` answers the previous one.
- R10: On a fault, `done_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 31 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load |
| root_base | input | 27 | Byte address of the root table |
| mem_req_valid | output | 1 | Single-cycle memory request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 27 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry written back |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Entry read |
| done_valid | output | 1 | Result present for one cycle |
| done_fault | output | 1 | Translation failed |
| done_paddr | output | 27 | Translated physical address |
| busy | output | 1 | Walk in progress |

## Verification
Two things can coincide in a single cycle. One is a new `req_valid` arriving while a walk is already in progress. The other is a memory response landing in that same cycle. The bench raises an extra request right after acceptance, and again at random points, while the memory model answers after a random 1 to 3 cycle latency. It then checks that the memory traffic for the walk matches the expected count exactly, and that only one result pulse appears. It also checks that a leaf write happens exactly when the expected leaf word differs from the stored one, so repeated accesses to the same page exercise the path where no write is needed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ENTRY_W = 32;
    localparam int V_BIT   = 31;
    localparam int U_BIT   = 30;
    localparam int D_BIT   = 29;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ROOT,
        S_WT_ROOT,
        S_RD_LEAF,
        S_WT_LEAF,
        S_WR_LEAF,
        S_WT_WR,
        S_REPORT
    } walk_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W     = 31,
    parameter int PA_W     = 27,
    parameter int OFF_W    = 12,
    parameter int L2_IDX_W = 10,
    parameter int PPN_W    = 15
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  root_base,
    input  logic [PA_W-1:0]  leaf_base,
    input  logic [PPN_W-1:0] leaf_ppn,
    output logic [PA_W-1:0]  root_addr,
    output logic [PA_W-1:0]  leaf_addr,
    output logic [PA_W-1:0]  paddr
);
    localparam int L1_IDX_W = VA_W - OFF_W - L2_IDX_W;
    localparam int L2_LSB   = OFF_W;
    localparam int L1_LSB   = OFF_W + L2_IDX_W;

    logic [L1_IDX_W-1:0] idx_root;
    logic [L2_IDX_W-1:0] idx_leaf;

    assign idx_root = vaddr[L1_LSB +: L1_IDX_W];
    assign idx_leaf = vaddr[L2_LSB +: L2_IDX_W];

    // entries are 4 bytes: index scaled by 4
    assign root_addr = root_base + {{(PA_W-L1_IDX_W-2){1'b0}}, idx_root, 2'b00};
    assign leaf_addr = leaf_base + {{(PA_W-L2_IDX_W-2){1'b0}}, idx_leaf, 2'b00};
    assign paddr     = {leaf_ppn, vaddr[OFF_W-1:0]};

endmodule

// File: rtl/ptw_entry_upd.sv
module ptw_entry_upd
    import ptw_pkg::*;
(
    input  logic [ENTRY_W-1:0] old_entry,
    input  logic               is_store,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               changed
);
    always_comb begin
        new_entry        = old_entry;
        new_entry[U_BIT] = 1'b1;
        if (is_store) begin
            new_entry[D_BIT] = 1'b1;
        end
        changed = (new_entry != old_entry);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W     = 31,
    parameter int PA_W     = 27,
    parameter int OFF_W    = 12,
    parameter int L2_IDX_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_store,
    input  logic [PA_W-1:0]    root_base,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic [ENTRY_W-1:0] mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_rdata,
    output logic               done_valid,
    output logic               done_fault,
    output logic [PA_W-1:0]    done_paddr,
    output logic               busy
);
    localparam int PPN_W = PA_W - OFF_W;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]    va_q;
    logic               store_q;
    logic [PA_W-1:0]    leaf_base_q;
    logic [PA_W-1:0]    leaf_addr_q;
    logic [ENTRY_W-1:0] wb_q;
    logic [PA_W-1:0]    paddr_q;
    logic               fault_q;

    logic [PA_W-1:0]    root_addr_c, leaf_addr_c, paddr_c;
    logic [ENTRY_W-1:0] upd_entry_c;
    logic               upd_changed_c;

    ptw_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
        .L2_IDX_W(L2_IDX_W), .PPN_W(PPN_W)
    ) u_addr (
        .vaddr     (va_q),
        .root_base (root_base),
        .leaf_base (leaf_base_q),
        .leaf_ppn  (mem_rsp_rdata[PPN_W-1:0]),
        .root_addr (root_addr_c),
        .leaf_addr (leaf_addr_c),
        .paddr     (paddr_c)
    );

    ptw_entry_upd u_upd (
        .old_entry (mem_rsp_rdata),
        .is_store  (store_q),
        .new_entry (upd_entry_c),
        .changed   (upd_changed_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_RD_ROOT;
            S_RD_ROOT: state_d = S_WT_ROOT;
            S_WT_ROOT: if (mem_rsp_valid)
                           state_d = mem_rsp_rdata[V_BIT] ? S_RD_LEAF : S_REPORT;
            S_RD_LEAF: state_d = S_WT_LEAF;
            S_WT_LEAF: if (mem_rsp_valid)
                           state_d = (mem_rsp_rdata[V_BIT] && upd_changed_c)
                                     ? S_WR_LEAF : S_REPORT;
            S_WR_LEAF: state_d = S_WT_WR;
            S_WT_WR:   if (mem_rsp_valid) state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            store_q     <= 1'b0;
            leaf_base_q <= '0;
            leaf_addr_q <= '0;
            wb_q        <= '0;
            paddr_q     <= '0;
            fault_q     <= 1'b0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                va_q    <= req_vaddr;
                store_q <= req_store;
                paddr_q <= '0;
                fault_q <= 1'b0;
            end
            if (state_q == S_WT_ROOT && mem_rsp_valid) begin
                if (mem_rsp_rdata[V_BIT]) leaf_base_q <= mem_rsp_rdata[PA_W-1:0];
                else                      fault_q     <= 1'b1;
            end
            if (state_q == S_RD_LEAF) begin
                leaf_addr_q <= leaf_addr_c;
            end
            if (state_q == S_WT_LEAF && mem_rsp_valid) begin
                if (mem_rsp_rdata[V_BIT]) begin
                    paddr_q <= paddr_c;
                    wb_q    <= upd_entry_c;
                end else begin
                    fault_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        busy          = (state_q != S_IDLE);
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        done_valid    = 1'b0;
        unique case (state_q)
            S_RD_ROOT: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = root_addr_c;
            end
            S_RD_LEAF: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = leaf_addr_c;
            end
            S_WR_LEAF: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = leaf_addr_q;
                mem_req_wdata = wb_q;
            end
            S_REPORT:  done_valid = 1'b1;
            default:   ;
        endcase
        done_fault = done_valid & fault_q;
        done_paddr = done_valid ? paddr_q : '0;
    end

    // R9
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R8
    wb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[V_BIT] && mem_req_wdata[U_BIT]));

    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_fault |-> (done_valid && done_paddr == '0));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!busy && req_ready));

    // R9
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 31;
    localparam int PA_W = 27;
    localparam logic [PA_W-1:0] ROOT = 27'h0100000;
    localparam logic [PA_W-1:0] LEAF0 = 27'h0200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_store = 1'b0;
    logic [PA_W-1:0] root_base = ROOT;
    logic mem_req_valid, mem_req_write;
    logic [PA_W-1:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic done_valid, done_fault, busy;
    logic [PA_W-1:0] done_paddr;

    int checks = 0;
    int fails = 0;

    logic [31:0] pmem [int unsigned];

    int n_rd, n_wr, n_done, n_idle_busy;
    logic [PA_W-1:0] first_rd_addr, second_rd_addr, wr_addr;
    logic [31:0] wr_data;
    logic monitoring = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_store(req_store), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done_valid(done_valid), .done_fault(done_fault),
        .done_paddr(done_paddr), .busy(busy)
    );

    function automatic logic [31:0] rd(logic [PA_W-1:0] a);
        int unsigned k = int'(a);
        return pmem.exists(k) ? pmem[k] : 32'h0;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // memory model: answers each request after 1..3 cycles
    initial begin
        bit pending = 0;
        int cnt = 0;
        logic wr_p = 0;
        logic [PA_W-1:0] a_p = '0;
        logic [31:0] d_p = '0;
        void'($urandom(32'h5eed));
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pending) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = wr_p ? 32'h0 : rd(a_p);
                    if (wr_p) pmem[int'(a_p)] = d_p;
                    pending = 0;
                end else begin
                    cnt--;
                end
            end
            if (mem_req_valid && rst_n) begin
                // R9: no request while one is outstanding
                chk(!pending, "R9", "request while outstanding", 1, 0);
                pending = 1;
                cnt = int'($urandom_range(0, 2));
                wr_p = mem_req_write;
                a_p = mem_req_addr;
                d_p = mem_req_wdata;
            end
        end
    end

    // traffic monitor
    initial begin
        forever begin
            @(negedge clk);
            if (monitoring) begin
                if (mem_req_valid && !mem_req_write) begin
                    if (n_rd == 0) first_rd_addr = mem_req_addr;
                    else second_rd_addr = mem_req_addr;
                    n_rd++;
                end
                if (mem_req_valid && mem_req_write) begin
                    n_wr++;
                    wr_addr = mem_req_addr;
                    wr_data = mem_req_wdata;
                end
                if (done_valid) n_done++;
            end
        end
    end

    task automatic walk(logic [VA_W-1:0] va, bit st, bit poke);
        logic [PA_W-1:0] a1, a2;
        logic [31:0] e1, e2, nw;
        bit exp_fault, exp_wr;
        int exp_rd;
        logic [PA_W-1:0] exp_pa;
        bit seen = 0;
        bit res_fault = 0;
        logic [PA_W-1:0] res_pa = '0;
        int guard = 0;

        a1 = ROOT + {5'b0, va[30:22], 2'b00};
        e1 = rd(a1);
        a2 = e1[26:0] + {15'b0, va[21:12], 2'b00};
        e2 = rd(a2);
        nw = e2 | 32'h4000_0000 | (st ? 32'h2000_0000 : 32'h0);
        exp_fault = !e1[31] || !e2[31];
        exp_rd = e1[31] ? 2 : 1;
        exp_wr = !exp_fault && (nw != e2);
        exp_pa = exp_fault ? '0 : {e2[14:0], va[11:0]};

        n_rd = 0; n_wr = 0; n_done = 0; n_idle_busy = 0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R2", "ready before request", req_ready, 1);
        req_vaddr = va; req_store = st; req_valid = 1'b1;
        monitoring = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_vaddr = ~va; req_store = ~st; req_valid = 1'b1;
        end
        while (!seen && guard < 60) begin
            if (!busy) n_idle_busy++;
            if (done_valid) begin
                seen = 1;
                res_fault = done_fault;
                res_pa = done_paddr;
            end else begin
                @(negedge clk);
                req_valid = 1'b0;
                guard++;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R2", "busy after result", busy, 0);
        repeat (3) @(negedge clk);
        monitoring = 1'b0;

        chk(seen, "R2", "result reported", seen, 1);
        chk(n_idle_busy == 0, "R2", "busy low during walk", n_idle_busy, 0);
        chk(n_done == 1, "R2", "result pulses", n_done, 1);
        chk(first_rd_addr == a1, "R3", "root entry address", first_rd_addr, a1);
        chk(n_rd == exp_rd, e1[31] ? "R5" : "R4", "read count", n_rd, exp_rd);
        if (e1[31])
            chk(second_rd_addr == a2, "R5", "leaf entry address", second_rd_addr, a2);
        chk(res_fault == exp_fault, e1[31] ? "R6" : "R4", "fault flag", res_fault, exp_fault);
        if (exp_fault)
            chk(res_pa == '0, "R10", "paddr on fault", res_pa, 0);
        else
            chk(res_pa == exp_pa, "R7", "physical address", res_pa, exp_pa);
        chk(n_wr == int'(exp_wr), exp_fault ? "R6" : "R8", "write count", n_wr, exp_wr);
        if (exp_wr) begin
            chk(wr_addr == a2, "R8", "write address", wr_addr, a2);
            chk(wr_data == nw, "R8", "written entry", wr_data, nw);
            chk(rd(a2) == nw, "R8", "stored entry", rd(a2), nw);
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // root entries 0..3; entry 2 left invalid
        for (int k = 0; k < 4; k++) begin
            if (k != 2)
                pmem[int'(ROOT) + k*4] = 32'h8000_0000 | (32'(LEAF0) + 32'(k) * 32'h1000);
        end
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] e;
                e = {$urandom_range(0,3) != 0, 1'($urandom), 1'($urandom), 14'b0,
                     15'($urandom)};
                pmem[int'(LEAF0) + k*32'h1000 + j*4] = e;
            end
        end
        // directed example leaf
        pmem[int'(LEAF0) + 32'h3FE*4] = 32'h8000_23F1;
        pmem[int'(LEAF0) + 32'h3FD*4] = 32'h0000_1234;

        repeat (3) @(negedge clk);
        // R1
        chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
        chk(done_valid === 1'b0, "R1", "done in reset", done_valid, 0);
        chk(mem_req_valid === 1'b0, "R1", "mem request in reset", mem_req_valid, 0);
        chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 example: 0x003FEFB0 -> 0x23F1FB0
        walk(31'h003FEFB0, 1'b0, 1'b0);
        chk(rd(LEAF0 + 27'h3FE*4) == 32'hC000_23F1, "R8", "use bit after load",
            rd(LEAF0 + 27'h3FE*4), 32'hC000_23F1);
        walk(31'h003FEFB0, 1'b0, 1'b1);   // R8 unchanged: no write; R2 poke
        walk(31'h003FE004, 1'b1, 1'b0);   // R8 store sets modified
        walk(31'h003FE004, 1'b1, 1'b1);   // R8 no write again
        walk(31'h003FD123, 1'b0, 1'b0);   // R6 leaf invalid
        walk(31'h00800ABC, 1'b1, 1'b1);   // R4 root invalid (index 2)
        walk(31'h7FC00000, 1'b0, 1'b0);   // R4 root index 511 unset

        for (int i = 0; i < 150; i++) begin
            logic [VA_W-1:0] va;
            va = {7'b0, 2'($urandom), 7'b0, 3'($urandom), 12'($urandom)};
            walk(va, 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule